// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a 32-bit processor core whose datapath is organised around one shared transfer bus. Each cycle exactly one source (program counter, address unit, adder, register file or memory read-data register) places a value on the bus, and any number of destination registers may capture it. A hardwired state machine breaks every instruction into a fixed sequence of micro-steps, so the cost of an instruction is set by its class and never by its operands (except for the branch outcome).

The core talks to a combinational memory through one request port: a valid strobe, a read/write flag, an address taken straight from the bus, and write data from a dedicated store-data register. The read response is captured in the cycle of the request and consumed in the next one. The register file has one port, so no step reads two registers, and no step makes two memory accesses. It is meant to sit beside a simple single-ported memory wherever a tiny controller is needed and area matters more than instructions per cycle.

Top module: `sbus_core`

## Requirements
- R1: After reset is released the core is in the first fetch step with PC = 0, so in that cycle it issues a read (memReqOp = 0; 1 means write) at address 0. Every instruction begins with a read request at its own PC.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], imm [15:0], target [25:0]. addu (opcode 0, shamt 0, funct 0x21) writes rs+rt to rd, and addiu (opcode 0x09) writes rs+sext(imm) to rt; each takes 6 cycles from its fetch to the next fetch.
- R3: lw (opcode 0x23) reads the word at rs+sext(imm) into rt, and sw (opcode 0x2B) writes rt to rs+sext(imm); each takes 7 cycles.
- R4: mul (opcode 0x1C, shamt 0, funct 0x02) writes the low 32 bits of rs*rt to rd, signed or unsigned alike, and takes 38 cycles.
- R5: j (opcode 0x02) sets PC to the upper 4 bits of PC+4 joined with target<<2 in 5 cycles; jal (opcode 0x03) does the same after writing PC+4 to register 31, in 6 cycles.
- R6: jr (opcode 0, shamt 0, funct 0x08) sets PC to rs in 4 cycles.
- R7: bne (opcode 0x05) sets PC to PC+4+(sext(imm)<<2) when rs differs from rt, taking 8 cycles; when they are equal it falls through to PC+4 in 6 cycles.
- R8: Register 0 reads as zero and every write to it is discarded.
- R9: Any other opcode, an R-type funct other than 0x21/0x08, a nonzero shamt on an R-type or mul word, or a mul-opcode word with funct other than 0x02, takes 3 cycles and leaves registers and memory unchanged.
- R10: In every cycle at most one bus source is enabled, exactly one when any destination loads from the bus, and a memory write happens only in the last step of a store, so the number of writes equals the number of executed stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memReqVal | output | 1 | Memory request valid this cycle |
| memReqOp | output | 1 | 0 = read, 1 = write |
| memReqAddr | output | 32 | Byte address (bus value) |
| memReqData | output | 32 | Store data |
| memRespData | input | 32 | Combinational read data for the current request |

## Verification
Two things share a single cycle in the branch sequence: the equality status is judged from the A and B registers in the same step that overwrites A with the scaled offset, so a wrong ordering would compare against the offset instead of rs. Taken and not-taken branches are both provoked (a counting loop and an equal-operand branch) and judged by the landing address of the next fetch and by the 8-versus-6 cycle spacing between fetches. The fetch increment step likewise updates PC and picks the next state from the freshly loaded instruction word, which every fetch-to-fetch spacing check covers.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int XLEN    = 32;
  localparam int REG_AW  = 5;
  localparam int NREG    = 1 << REG_AW;
  localparam int LINKREG = NREG - 1;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_MULG  = 6'h1C;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_JR    = 6'h08;
  localparam logic [5:0] FN_MUL   = 6'h02;

  typedef enum logic [1:0] {ALU_INC4, ALU_ADD, ALU_CADD} aluOp_e;
  typedef enum logic [1:0] {IAU_SEXT, IAU_SEXT2, IAU_TGT2, IAU_JT} iauOp_e;
  typedef enum logic [2:0] {RS_RS, RS_RT, RS_RD, RS_LINK, RS_ZERO} rfSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   pcBus;
    logic   iauBus;
    logic   aluBus;
    logic   rfBus;
    logic   rdBus;
    logic   pcEn;
    logic   irEn;
    logic   aEn;
    logic   bEn;
    logic   cEn;
    logic   wdEn;
    logic   bShift;
    logic   cShift;
    aluOp_e aluOp;
    iauOp_e iauOp;
    rfSel_e rfSel;
    logic   rfWen;
    logic   memVal;
    logic   memWr;
  } ctrl_t;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [1:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wen && addr != '0) regs[addr] <= wdata;
  end

  always_comb begin
    if (addr == '0) rdata = '0;
    else            rdata = regs[addr];
  end
endmodule

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        ctl,
  input  logic [W-1:0] memRespData,
  output logic [W-1:0] busVal,
  output logic [W-1:0] wdOut,
  output logic [5:0]   irOp,
  output logic [10:0]  irLow,
  output logic         eq
);
  localparam int IMMW = 16;
  localparam int TGTW = 26;
  localparam int JHI  = TGTW + 2;

  logic [W-1:0] pcQ, irQ, aQ, bQ, cQ, wdQ, rdQ;
  logic [W-1:0] sextImm, iauVal, aluVal, rfRdata;
  logic [AW-1:0] rfAddr;

  assign sextImm = {{(W-IMMW){irQ[IMMW-1]}}, irQ[IMMW-1:0]};

  always_comb begin
    case (ctl.iauOp)
      IAU_SEXT:  iauVal = sextImm;
      IAU_SEXT2: iauVal = sextImm << 2;
      IAU_TGT2:  iauVal = {{(W-JHI){1'b0}}, irQ[TGTW-1:0], 2'b00};
      default:   iauVal = {aQ[W-1:JHI], bQ[JHI-1:0]};
    endcase
  end

  always_comb begin
    case (ctl.aluOp)
      ALU_INC4: aluVal = aQ + W'(4);
      ALU_ADD:  aluVal = aQ + bQ;
      ALU_CADD: aluVal = cQ[0] ? (aQ + bQ) : aQ;
      default:  aluVal = aQ;
    endcase
  end

  always_comb begin
    case (ctl.rfSel)
      RS_RS:   rfAddr = irQ[25:21];
      RS_RT:   rfAddr = irQ[20:16];
      RS_RD:   rfAddr = irQ[15:11];
      RS_LINK: rfAddr = AW'(LINKREG);
      default: rfAddr = '0;
    endcase
  end

  // single shared bus: OR of gated sources, one enabled at a time
  assign busVal = ({W{ctl.pcBus}}  & pcQ)
                | ({W{ctl.iauBus}} & iauVal)
                | ({W{ctl.aluBus}} & aluVal)
                | ({W{ctl.rfBus}}  & rfRdata)
                | ({W{ctl.rdBus}}  & rdQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0; irQ <= '0; aQ <= '0; bQ <= '0;
      cQ  <= '0; wdQ <= '0; rdQ <= '0;
    end else begin
      if (ctl.pcEn) pcQ <= busVal;
      if (ctl.irEn) irQ <= busVal;
      if (ctl.aEn)  aQ  <= busVal;
      if (ctl.bEn)  bQ  <= ctl.bShift ? (bQ << 1) : busVal;
      if (ctl.cEn)  cQ  <= ctl.cShift ? (cQ >> 1) : busVal;
      if (ctl.wdEn) wdQ <= busVal;
      if (ctl.memVal && !ctl.memWr) rdQ <= memRespData;
    end
  end

  sbus_regfile #(.W(W), .AW(AW)) u_rf (
    .clk   (clk),
    .wen   (ctl.rfWen),
    .addr  (rfAddr),
    .wdata (busVal),
    .rdata (rfRdata)
  );

  assign wdOut = wdQ;
  assign irOp  = irQ[31:26];
  assign irLow = irQ[10:0];
  assign eq    = (aQ == bQ);
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int STEPS = XLEN
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  irOp,
  input  logic [10:0] irLow,
  input  logic        eq,
  output ctrl_t       ctl
);
  localparam int CW = $clog2(STEPS);

  typedef enum logic [5:0] {
    S_F0, S_F1, S_F2,
    S_AD0, S_AD1, S_AD2,
    S_AI0, S_AI1, S_AI2,
    S_M0, S_M1, S_M2, S_MS,
    S_L0, S_L1, S_L2, S_L3,
    S_S0, S_S1, S_S2, S_S3,
    S_J0, S_J1, S_JA0, S_JR0,
    S_B0, S_B1, S_B2, S_B3, S_B4
  } state_e;

  state_e stQ, stN, dispatch;
  logic [CW-1:0] stepQ;
  logic lastStep;
  logic [5:0] fn;
  logic shamtZero;

  assign fn        = irLow[5:0];
  assign shamtZero = (irLow[10:6] == '0);
  assign lastStep  = (stepQ == CW'(STEPS - 1));

  always_comb begin
    dispatch = S_F0;
    case (irOp)
      OP_RTYPE: begin
        if (shamtZero && fn == FN_ADDU)    dispatch = S_AD0;
        else if (shamtZero && fn == FN_JR) dispatch = S_JR0;
      end
      OP_MULG:  if (shamtZero && fn == FN_MUL) dispatch = S_M0;
      OP_ADDIU: dispatch = S_AI0;
      OP_LW:    dispatch = S_L0;
      OP_SW:    dispatch = S_S0;
      OP_J:     dispatch = S_J0;
      OP_JAL:   dispatch = S_JA0;
      OP_BNE:   dispatch = S_B0;
      default:  dispatch = S_F0;
    endcase
  end

  always_comb begin
    ctl = '0;
    stN = stQ;
    case (stQ)
      S_F0:  begin ctl.pcBus = 1'b1; ctl.aEn = 1'b1; ctl.memVal = 1'b1; stN = S_F1; end
      S_F1:  begin ctl.rdBus = 1'b1; ctl.irEn = 1'b1; stN = S_F2; end
      S_F2:  begin
        ctl.aluBus = 1'b1; ctl.aluOp = ALU_INC4; ctl.pcEn = 1'b1; ctl.aEn = 1'b1;
        stN = dispatch;
      end
      S_AD0: begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.aEn = 1'b1; stN = S_AD1; end
      S_AD1: begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RT; ctl.bEn = 1'b1; stN = S_AD2; end
      S_AD2: begin
        ctl.aluBus = 1'b1; ctl.aluOp = ALU_ADD; ctl.rfSel = RS_RD; ctl.rfWen = 1'b1;
        stN = S_F0;
      end
      S_AI0: begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.aEn = 1'b1; stN = S_AI1; end
      S_AI1: begin ctl.iauBus = 1'b1; ctl.iauOp = IAU_SEXT; ctl.bEn = 1'b1; stN = S_AI2; end
      S_AI2: begin
        ctl.aluBus = 1'b1; ctl.aluOp = ALU_ADD; ctl.rfSel = RS_RT; ctl.rfWen = 1'b1;
        stN = S_F0;
      end
      S_M0:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_ZERO; ctl.aEn = 1'b1; stN = S_M1; end
      S_M1:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.bEn = 1'b1; stN = S_M2; end
      S_M2:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RT; ctl.cEn = 1'b1; stN = S_MS; end
      S_MS:  begin
        ctl.aluBus = 1'b1; ctl.aluOp = ALU_CADD; ctl.aEn = 1'b1;
        ctl.bEn = 1'b1; ctl.bShift = 1'b1; ctl.cEn = 1'b1; ctl.cShift = 1'b1;
        if (lastStep) begin
          ctl.rfSel = RS_RD; ctl.rfWen = 1'b1; stN = S_F0;
        end
      end
      S_L0:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.aEn = 1'b1; stN = S_L1; end
      S_L1:  begin ctl.iauBus = 1'b1; ctl.iauOp = IAU_SEXT; ctl.bEn = 1'b1; stN = S_L2; end
      S_L2:  begin ctl.aluBus = 1'b1; ctl.aluOp = ALU_ADD; ctl.memVal = 1'b1; stN = S_L3; end
      S_L3:  begin ctl.rdBus = 1'b1; ctl.rfSel = RS_RT; ctl.rfWen = 1'b1; stN = S_F0; end
      S_S0:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RT; ctl.wdEn = 1'b1; stN = S_S1; end
      S_S1:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.aEn = 1'b1; stN = S_S2; end
      S_S2:  begin ctl.iauBus = 1'b1; ctl.iauOp = IAU_SEXT; ctl.bEn = 1'b1; stN = S_S3; end
      S_S3:  begin
        ctl.aluBus = 1'b1; ctl.aluOp = ALU_ADD; ctl.memVal = 1'b1; ctl.memWr = 1'b1;
        stN = S_F0;
      end
      S_JA0: begin ctl.pcBus = 1'b1; ctl.rfSel = RS_LINK; ctl.rfWen = 1'b1; stN = S_J0; end
      S_J0:  begin ctl.iauBus = 1'b1; ctl.iauOp = IAU_TGT2; ctl.bEn = 1'b1; stN = S_J1; end
      S_J1:  begin ctl.iauBus = 1'b1; ctl.iauOp = IAU_JT; ctl.pcEn = 1'b1; stN = S_F0; end
      S_JR0: begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.pcEn = 1'b1; stN = S_F0; end
      S_B0:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RS; ctl.aEn = 1'b1; stN = S_B1; end
      S_B1:  begin ctl.rfBus = 1'b1; ctl.rfSel = RS_RT; ctl.bEn = 1'b1; stN = S_B2; end
      S_B2:  begin
        ctl.iauBus = 1'b1; ctl.iauOp = IAU_SEXT2; ctl.aEn = 1'b1;
        stN = eq ? S_F0 : S_B3;
      end
      S_B3:  begin ctl.pcBus = 1'b1; ctl.bEn = 1'b1; stN = S_B4; end
      S_B4:  begin ctl.aluBus = 1'b1; ctl.aluOp = ALU_ADD; ctl.pcEn = 1'b1; stN = S_F0; end
      default: stN = S_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ   <= S_F0;
      stepQ <= '0;
    end else begin
      stQ   <= stN;
      stepQ <= (stQ == S_MS) ? stepQ + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic            memReqVal,
  output logic            memReqOp,
  output logic [XLEN-1:0] memReqAddr,
  output logic [XLEN-1:0] memReqData,
  input  logic [XLEN-1:0] memRespData
);
  ctrl_t            ctl;
  logic [XLEN-1:0]  busVal;
  logic [XLEN-1:0]  wdOut;
  logic [5:0]       irOp;
  logic [10:0]      irLow;
  logic             eq;

  sbus_ctrl #(.STEPS(XLEN)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .irOp  (irOp),
    .irLow (irLow),
    .eq    (eq),
    .ctl   (ctl)
  );

  sbus_dpath #(.W(XLEN), .AW(REG_AW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .memRespData (memRespData),
    .busVal      (busVal),
    .wdOut       (wdOut),
    .irOp        (irOp),
    .irLow       (irLow),
    .eq          (eq)
  );

  assign memReqVal  = ctl.memVal;
  assign memReqOp   = ctl.memWr;
  assign memReqAddr = busVal;
  assign memReqData = wdOut;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  busEn,
  input logic        busLoad,
  input logic        zeroRead,
  input logic [31:0] busVal,
  input logic        memReqVal,
  input logic        memReqOp,
  input logic [31:0] memReqAddr
);
  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (memReqVal && !memReqOp && memReqAddr == 32'd0));

  a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busEn));

  a_r10_one_driver_when_loaded: assert property (@(posedge clk) disable iff (rst)
    busLoad |-> ($countones(busEn) == 1));

  a_r10_no_back_to_back_write: assert property (@(posedge clk) disable iff (rst)
    (memReqVal && memReqOp) |=> !(memReqVal && memReqOp));

  a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    zeroRead |-> (busVal == 32'd0));
endmodule

bind sbus_core sbus_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busEn      ({ctl.pcBus, ctl.iauBus, ctl.aluBus, ctl.rfBus, ctl.rdBus}),
  .busLoad    (ctl.pcEn | ctl.irEn | ctl.aEn | ctl.wdEn | ctl.rfWen | ctl.memVal
               | (ctl.bEn & ~ctl.bShift) | (ctl.cEn & ~ctl.cShift)),
  .zeroRead   (ctl.rfBus && ctl.rfSel == sbus_pkg::RS_ZERO),
  .busVal     (busVal),
  .memReqVal  (memReqVal),
  .memReqOp   (memReqOp),
  .memReqAddr (memReqAddr)
);

// File: tb/sbus_core_test.sv
`timescale 1ns/1ps
module sbus_core_test;
  localparam int MW = 1024;
  localparam int CODE_END = 32'h400;

  typedef struct {
    int    pc;
    int    cyc;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memReqVal, memReqOp;
  logic [31:0] memReqAddr, memReqData, memRespData;

  logic [31:0] mem  [0:MW-1];
  logic [31:0] gmem [0:MW-1];
  logic [31:0] img  [0:MW-1];
  logic [31:0] greg [0:31];

  exp_t expQ [$];
  int   nChk = 0, nFail = 0;
  int   cycNow = 0, lastFetch = 0;
  int   wrCount = 0, gStores = 0;
  bit   running = 0;

  always #4 clk = ~clk;

  sbus_core uut (
    .clk(clk), .rst(rst),
    .memReqVal(memReqVal), .memReqOp(memReqOp),
    .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memRespData(memRespData)
  );

  assign memRespData = mem[memReqAddr[11:2]];

  always @(posedge clk) begin
    if (!rst && memReqVal && memReqOp) begin
      mem[memReqAddr[11:2]] <= memReqData;
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: each fetch pops one expected item (pc, spacing)
  always @(negedge clk) begin
    cycNow++;
    if (running && !rst && memReqVal && !memReqOp && memReqAddr < CODE_END
        && expQ.size() != 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(memReqAddr == e.pc, e.tag, "fetch pc", memReqAddr, e.pc);
      if (e.cyc >= 0)
        check(cycNow - lastFetch == e.cyc, e.tag, "cycles", cycNow - lastFetch, e.cyc);
      lastFetch = cycNow;
    end
  end

  function automatic logic [31:0] encR(int fn, int rs, int rt, int rd, int sh = 0, int op = 0);
    return {6'(op), 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int op, int addr);
    return {6'(op), 26'(addr >> 2)};
  endfunction

  task automatic gwr(input int r, input logic [31:0] v);
    if (r != 0) greg[r] = v;
  endtask

  // instruction-level golden model; pushes the expected fetch stream
  task automatic runGolden(input int haltPc);
    logic [31:0] pc, npc, ins, sx;
    int op, rs, rt, rd, sh, fn, cyc;
    string tag;
    exp_t e;
    pc = 0;
    gStores = 0;
    for (int i = 0; i < 32; i++) greg[i] = '0;
    e.pc = 0; e.cyc = -1; e.tag = "R1"; expQ.push_back(e);
    for (int n = 0; n < 4000; n++) begin
      ins = gmem[pc[11:2]];
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      sh = ins[10:6]; fn = ins[5:0];
      sx = {{16{ins[15]}}, ins[15:0]};
      npc = pc + 4; cyc = 3; tag = "R9";
      case (op)
        0: begin
          if (sh == 0 && fn == 'h21) begin gwr(rd, greg[rs] + greg[rt]); cyc = 6; tag = "R2"; end
          else if (sh == 0 && fn == 'h08) begin npc = greg[rs]; cyc = 4; tag = "R6"; end
        end
        'h1C: if (sh == 0 && fn == 2) begin gwr(rd, greg[rs] * greg[rt]); cyc = 38; tag = "R4"; end
        'h09: begin gwr(rt, greg[rs] + sx); cyc = 6; tag = "R2"; end
        'h23: begin gwr(rt, gmem[((greg[rs] + sx) >> 2) % MW]); cyc = 7; tag = "R3"; end
        'h2B: begin gmem[((greg[rs] + sx) >> 2) % MW] = greg[rt]; gStores++; cyc = 7; tag = "R3"; end
        'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; cyc = 5; tag = "R5"; end
        'h03: begin gwr(31, pc + 4); npc = {npc[31:28], ins[25:0], 2'b00}; cyc = 6; tag = "R5"; end
        'h05: begin
          tag = "R7";
          if (greg[rs] != greg[rt]) begin npc = pc + 4 + (sx << 2); cyc = 8; end
          else cyc = 6;
        end
        default: ;
      endcase
      e.pc = npc; e.cyc = cyc; e.tag = tag; expQ.push_back(e);
      if (npc == haltPc) break;
      pc = npc;
    end
  endtask

  task automatic runProgram(input int haltPc, input string name);
    for (int i = 0; i < MW; i++) begin mem[i] = img[i]; gmem[i] = img[i]; end
    runGolden(haltPc);
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; wrCount = 0;
    #1;
    // R1: first cycle after reset is a read at address 0
    check(memReqVal && !memReqOp && memReqAddr == 0, "R1", "reset fetch",
          {memReqVal, memReqOp, memReqAddr}, {1'b1, 1'b0, 32'h0});
    running = 1;
    for (int g = 0; g < 20000 && expQ.size() != 0; g++) @(negedge clk);
    check(expQ.size() == 0, "R1", {name, " fetch stream drained"}, expQ.size(), 0);
    expQ.delete();
    repeat (2) @(negedge clk);
    running = 0;
    for (int w = 256; w < 352; w++) begin
      string t;
      t = (w == 'h140) ? "R8" : (w == 'h143) ? "R9" : "R3";
      check(mem[w] === gmem[w], t, $sformatf("%s mem[%0h]", name, w * 4), mem[w], gmem[w]);
    end
    check(wrCount == gStores, "R10", {name, " write count"}, wrCount, gStores);
  endtask

  initial begin
    for (int i = 0; i < MW; i++) img[i] = '0;
    // vector add loop, n = 4
    img[0]  = encI('h09, 0, 4, 'h400);
    img[1]  = encI('h09, 0, 5, 'h420);
    img[2]  = encI('h09, 0, 6, 'h440);
    img[3]  = encI('h09, 0, 7, 4);
    img[4]  = encI('h23, 4, 12, 0);
    img[5]  = encI('h23, 5, 13, 0);
    img[6]  = encR('h21, 12, 13, 14);
    img[7]  = encI('h2B, 6, 14, 0);
    img[8]  = encI('h09, 4, 4, 4);
    img[9]  = encI('h09, 5, 5, 4);
    img[10] = encI('h09, 6, 6, 4);
    img[11] = encI('h09, 7, 7, -1);
    img[12] = encI('h05, 7, 0, -9);
    img[13] = encJ('h02, 52);
    img[256] = 32'd5;        img[257] = 32'hFFFF_FFFD;
    img[258] = 32'h7FFF_FFFF; img[259] = 32'd100;
    img[264] = 32'd7;        img[265] = 32'd3;
    img[266] = 32'd1;        img[267] = 32'hFFFF_FF00;
    runProgram(52, "vadd");

    for (int i = 0; i < MW; i++) img[i] = '0;
    img[0]  = encI('h09, 0, 1, -7);
    img[1]  = encI('h09, 0, 2, 13);
    img[2]  = encR(2, 1, 2, 3, 0, 'h1C);
    img[3]  = encI('h09, 0, 10, 'h400);
    img[4]  = encI('h23, 10, 5, 0);
    img[5]  = encR(2, 5, 5, 6, 0, 'h1C);
    img[6]  = encR('h21, 1, 2, 0);
    img[7]  = encI('h09, 0, 0, 5);
    img[8]  = encJ('h03, 100);
    img[9]  = encI('h05, 1, 1, 5);
    img[10] = 32'hFC00_0000;
    img[11] = encR('h3F, 1, 2, 3);
    img[12] = encJ('h02, 56);
    img[13] = encI('h09, 0, 3, 1);
    img[14] = encI('h2B, 0, 0, 'h500);
    img[15] = encI('h2B, 0, 1, 'h504);
    img[16] = encI('h2B, 0, 2, 'h508);
    img[17] = encI('h2B, 0, 3, 'h50C);
    img[18] = encI('h2B, 0, 5, 'h510);
    img[19] = encI('h2B, 0, 6, 'h514);
    img[20] = encI('h2B, 0, 8, 'h518);
    img[21] = encI('h2B, 0, 31, 'h51C);
    img[22] = encJ('h02, 88);
    img[25] = encI('h09, 0, 8, 77);
    img[26] = encR('h08, 31, 0, 0);
    img[256] = 32'h1234_5678;
    img['h140] = 32'hDEAD_BEEF;
    img['h143] = 32'h0BAD_F00D;
    runProgram(88, "misc");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R1 watchdog actual=%0d expected=0", 150000);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule